// File: doc/BRIEF.md
# Serial Comma Word Aligner

This block sits behind a clock-recovery stage. It takes one recovered serial bit on every cycle where the bit enable is high and packs the bits into 10-bit characters. The first bit received becomes bit 0 of the character. Characters leave the block in pairs. The first word of a pair is marked by the rising edge of one strobe, and the second word is marked by the rising edge of a complementary strobe. Each strobe phase nominally lasts ten bit times.

When resynchronisation is enabled, the block watches every bit position of the stream for the 7-bit comma. If a comma is found off a character boundary, the block moves the character framing. If a comma is found on a boundary but inside a first-half word, the block also moves the framing. In both cases the next comma lands at bit 0 of a second-half word. The framing is always moved by lengthening a strobe phase, never by shortening one. A flag is raised for exactly the second-half word that holds an aligned comma. When resynchronisation is disabled, the framing stays where it is and the flag stays low.

Top module: `comma_word_aligner`

## Requirements
- R1: `char_out[0]` holds the earliest received bit of a character and `char_out[9]` holds the latest. When the stream is locked, the character that follows a comma character comes out complete and unchanged in the next first-half word.
- R2: A comma is present when `char_out[6:0]` equals 7'b1111100. That is, the serial order is 0,0,1,1,1,1,1 starting at bit 0. Bits 7 to 9 are ignored.
- R3: `half0_stb` and `half1_stb` are always complementary. A rise of `half0_stb` presents a first-half word, and a rise of `half1_stb` presents a second-half word. Each strobe phase nominally lasts ten bit-enable cycles.
- R4: With `resync_en` high, a stream of comma characters repeating every 20 bits, starting after any number of filler bits, has each comma from the second one onward presented at bit 0 of a second-half word with the flag high.
- R5: With `resync_en` high, a comma that lands on a character boundary in a first-half word is not presented in that word. Instead, the strobe phase that is running is stretched to 20 bit times.
- R6: No strobe high phase or low phase is ever shorter than ten bit-enable cycles.
- R7: A comma that is already aligned in a second-half word causes no change to the framing: every strobe phase stays exactly ten bits long.
- R8: `comma_seen` is high exactly while a second-half word that contains a comma is presented with `resync_en` high. It is low during every first-half word.
- R9: With `resync_en` low, the framing is frozen: every phase is exactly ten bits long whatever the data, and `comma_seen` stays low.
- R10: Synchronous reset drives `char_out` to zero, `half0_stb` low, `half1_stb` high and `comma_seen` low.
- R11: In a cycle where `bit_en` is low, the word output and the strobes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High on cycles that carry a recovered bit |
| bit_in | input | 1 | Recovered serial bit |
| resync_en | input | 1 | Enables comma search, realignment and the comma flag |
| char_out | output | 10 | Received character, bit 0 received first |
| half0_stb | output | 1 | Rises with each first-half word |
| half1_stb | output | 1 | Rises with each second-half word; complement of `half0_stb` |
| comma_seen | output | 1 | High while the presented second-half word holds an aligned comma |

## Verification
The framing state inside the block is a bit counter, a phase-length selector and a half indicator. An error in that state shows up as strobe phases that are not ten bits long, and these are visible at the first strobe edge after the fault. An error in the half indicator puts commas into first-half words. In that case the flag stays low where a comma is present, or the data character after a comma is wrong, and this shows within one word pair. A fault in the realignment logic leaves the stream unlocked. The bench sees this as missing flagged commas within a single burst of comma pairs.

// File: rtl/caw_pkg.sv
package caw_pkg;
  localparam int unsigned CHAR_W  = 10;
  localparam int unsigned COMMA_W = 7;
  // serial order 0,0,1,1,1,1,1 with bit 0 first
  localparam logic [COMMA_W-1:0] COMMA_BITS = 7'b1111100;

  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/caw_shifter.sv
module caw_shifter #(
  parameter int unsigned CHAR_W = caw_pkg::CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [CHAR_W-1:0] window_nxt
);
  logic [CHAR_W-1:0] window_q;

  // newest bit enters at the top; the oldest bit sits at index 0
  assign window_nxt[CHAR_W-1] = bit_in;
  genvar i;
  generate
    for (i = 0; i < CHAR_W - 1; i++) begin : g_shift
      assign window_nxt[i] = window_q[i+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      window_q <= '0;
    end else if (bit_en) begin
      window_q <= window_nxt;
    end
  end
endmodule

// File: rtl/caw_framer.sv
module caw_framer
  import caw_pkg::*;
#(
  parameter int unsigned CHAR_W = caw_pkg::CHAR_W
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_en,
  input  logic  resync_en,
  input  logic  match,
  output logic  emit,
  output half_e emit_half,
  output logic  flag_set
);
  localparam int unsigned CNT_W = $clog2(2 * CHAR_W);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(CHAR_W - 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(2 * CHAR_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             long_q;
  half_e            half_q;
  logic             bound;
  logic             skip;
  logic             slip;
  logic             hunt;

  always_comb begin
    hunt      = resync_en && match;
    bound     = (cnt_q == (long_q ? LONG_LIM : SHORT_LIM));
    skip      = bit_en && bound && hunt && (half_q == HALF_FIRST);
    emit      = bit_en && bound && !skip;
    slip      = bit_en && !bound && hunt;
    flag_set  = emit && hunt && (half_q == HALF_SECOND);
    emit_half = half_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
      half_q <= HALF_FIRST;
    end else if (bit_en) begin
      if (emit) begin
        cnt_q  <= '0;
        long_q <= 1'b0;
        half_q <= (half_q == HALF_FIRST) ? HALF_SECOND : HALF_FIRST;
      end else if (skip) begin
        // boundary comma in a first-half word: stretch by one character
        cnt_q  <= '0;
        long_q <= 1'b0;
      end else if (slip) begin
        // off-boundary comma: restart framing here, always lengthening
        cnt_q  <= '0;
        long_q <= (half_q == HALF_SECOND);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/caw_outreg.sv
module caw_outreg
  import caw_pkg::*;
#(
  parameter int unsigned CHAR_W = caw_pkg::CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  half_e             emit_half,
  input  logic              flag_set,
  input  logic              resync_en,
  input  logic [CHAR_W-1:0] data_in,
  output logic [CHAR_W-1:0] char_q,
  output logic              stb0_q,
  output logic              stb1_q,
  output logic              flag_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      char_q <= '0;
      stb0_q <= 1'b0;
      stb1_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (emit) begin
        char_q <= data_in;
        stb0_q <= (emit_half == HALF_FIRST);
        stb1_q <= (emit_half == HALF_SECOND);
      end
      flag_q <= resync_en && (emit ? flag_set : flag_q);
    end
  end
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import caw_pkg::*;
#(
  parameter int unsigned CHAR_W  = caw_pkg::CHAR_W,
  parameter int unsigned COMMA_W = caw_pkg::COMMA_W,
  parameter logic [COMMA_W-1:0] COMMA_BITS = caw_pkg::COMMA_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              resync_en,
  output logic [CHAR_W-1:0] char_out,
  output logic              half0_stb,
  output logic              half1_stb,
  output logic              comma_seen
);
  logic [CHAR_W-1:0] window_nxt;
  logic              match;
  logic              emit;
  half_e             emit_half;
  logic              flag_set;

  caw_shifter #(.CHAR_W(CHAR_W)) shift_i (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .window_nxt (window_nxt)
  );

  assign match = (window_nxt[COMMA_W-1:0] == COMMA_BITS);

  caw_framer #(.CHAR_W(CHAR_W)) frame_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .resync_en (resync_en),
    .match     (match),
    .emit      (emit),
    .emit_half (emit_half),
    .flag_set  (flag_set)
  );

  caw_outreg #(.CHAR_W(CHAR_W)) out_i (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .emit_half (emit_half),
    .flag_set  (flag_set),
    .resync_en (resync_en),
    .data_in   (window_nxt),
    .char_q    (char_out),
    .stb0_q    (half0_stb),
    .stb1_q    (half1_stb),
    .flag_q    (comma_seen)
  );
endmodule

// File: rtl/caw_checker.sv
module caw_checker #(
  parameter int unsigned CHAR_W  = 10,
  parameter int unsigned COMMA_W = 7,
  parameter logic [COMMA_W-1:0] COMMA_BITS = 7'b1111100
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              bit_in,
  input logic              resync_en,
  input logic [CHAR_W-1:0] char_out,
  input logic              half0_stb,
  input logic              half1_stb,
  input logic              comma_seen
);
  logic       prev0_q;
  logic [7:0] bits_q;
  logic       toggled;

  assign toggled = (half0_stb != prev0_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev0_q <= 1'b0;
      bits_q  <= '0;
    end else begin
      prev0_q <= half0_stb;
      if (toggled) bits_q <= {7'd0, bit_en};
      else if (bits_q != 8'hFF) bits_q <= bits_q + {7'd0, bit_en};
    end
  end

  a_r3_complementary: assert property (@(posedge clk) disable iff (rst)
    half0_stb != half1_stb);

  a_r6_phase_not_short: assert property (@(posedge clk) disable iff (rst)
    toggled |-> (bits_q >= 8'(CHAR_W)));

  a_r8_flag_in_second_half: assert property (@(posedge clk) disable iff (rst)
    comma_seen |-> (half1_stb && char_out[COMMA_W-1:0] == COMMA_BITS));

  a_r9_flag_low_when_frozen: assert property (@(posedge clk) disable iff (rst)
    !resync_en |=> !comma_seen);

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(char_out) && $stable(half0_stb)));

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (!comma_seen && !half0_stb && half1_stb && char_out == '0));
endmodule

bind comma_word_aligner caw_checker #(
  .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .COMMA_BITS(COMMA_BITS)
) chk_i (.*);

// File: tb/comma_word_aligner_tb_top.sv
module comma_word_aligner_tb_top;
  localparam logic [9:0] K28_5 = 10'h17C;  // serial 0011111010
  localparam logic [9:0] D21_5 = 10'h155;  // serial 1010101010

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, bit_en, bit_in, resync_en;
  logic [9:0] char_out;
  logic half0_stb, half1_stb, comma_seen;

  comma_word_aligner dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .resync_en(resync_en), .char_out(char_out), .half0_stb(half0_stb),
    .half1_stb(half1_stb), .comma_seen(comma_seen)
  );

  int checks = 0;
  int errors = 0;
  logic prev_sa, prev_sb, prev_f, last_en, last_second_comma;
  logic [9:0] prev_w;
  int phase_bits, max_phase, trial_commas;
  bit exact_mode;
  string exact_req;

  function automatic bit has_comma(logic [9:0] w);
    return w[6:0] == 7'b1111100;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic observe();
    logic sa, sb, f, exp_f;
    logic [9:0] w;
    sa = half0_stb; sb = half1_stb; f = comma_seen; w = char_out;
    check(sa != sb, "R3", "strobes complementary", sa, ~sb);
    if (!last_en)
      check(w == prev_w && sa == prev_sa && f == prev_f, "R11", "idle hold",
            w, prev_w);
    if (sa != prev_sa) begin
      check(phase_bits >= 10, "R6", "phase length", phase_bits, 10);
      if (exact_mode) check(phase_bits == 10, exact_req, "exact phase", phase_bits, 10);
      if (phase_bits > max_phase) max_phase = phase_bits;
      phase_bits = 0;
    end
    if (sb && !prev_sb) begin
      exp_f = resync_en && has_comma(w);
      check(f == exp_f, "R2,R8", "second-half flag", f, exp_f);
      if (f && w == K28_5) trial_commas++;
      last_second_comma = f;
    end
    if (sa && !prev_sa) begin
      check(f == 1'b0, "R8", "first-half flag", f, 0);
      if (last_second_comma) check(w == D21_5, "R1", "char after comma", w, D21_5);
      last_second_comma = 1'b0;
    end
    prev_sa = sa; prev_sb = sb; prev_f = f; prev_w = w;
  endtask

  task automatic step(bit en, bit b);
    @(negedge clk);
    observe();
    bit_en = en; bit_in = b; last_en = en;
    if (en) phase_bits++;
  endtask

  task automatic send_bit(bit b);
    if ($urandom_range(0, 3) == 0) step(1'b0, 1'b0);
    step(1'b1, b);
  endtask

  task automatic send_char(logic [9:0] c);
    for (int i = 0; i < 10; i++) send_bit(c[i]);
  endtask

  // random filler with no run of five ones, so it can hold no comma
  task automatic send_filler(int n);
    int run = 0;
    for (int i = 0; i < n; i++) begin
      bit b = 1'($urandom_range(0, 1));
      if (run == 4) b = 1'b0;
      run = b ? run + 1 : 0;
      send_bit(b);
    end
  endtask

  task automatic trial(int slip, string req);
    trial_commas = 0; max_phase = 0;
    send_filler(slip);
    for (int p = 0; p < 8; p++) begin
      if (p == 3) begin exact_mode = 1'b1; exact_req = "R7"; end
      send_char(K28_5);
      send_char(D21_5);
    end
    exact_mode = 1'b0;
    send_char(D21_5);
    step(1'b0, 1'b0);
    check(trial_commas >= 7, req, "aligned commas in burst", trial_commas, 7);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    check(char_out == '0, "R10", "reset char", char_out, 0);
    check(!half0_stb && half1_stb, "R10", "reset strobes", {half0_stb, half1_stb}, 1);
    check(!comma_seen, "R10", "reset flag", comma_seen, 0);
    rst = 1'b0;
    prev_sa = 1'b0; prev_sb = 1'b1; prev_f = 1'b0; prev_w = '0;
    last_en = 1'b0; phase_bits = 0; last_second_comma = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20250417));
    rst = 1'b1; bit_en = 1'b0; bit_in = 1'b0; resync_en = 1'b1;
    exact_mode = 1'b0; exact_req = "R7";
    do_reset();
    // R4 random bit slips
    for (int t = 0; t < 10; t++) trial($urandom_range(1, 25), "R4");
    // R5 boundary comma falling in a first-half word
    trial(0, "R4");
    check(max_phase == 20, "R5", "stretched phase", max_phase, 20);
    trial(7, "R4");
    // R9 frozen framing with a slip of three bits
    resync_en = 1'b0;
    trial_commas = 0;
    send_filler(3);
    exact_mode = 1'b1; exact_req = "R9";
    for (int p = 0; p < 6; p++) begin send_char(K28_5); send_char(D21_5); end
    send_char(D21_5);
    step(1'b0, 1'b0);
    exact_mode = 1'b0;
    check(trial_commas == 0, "R9", "no flag while frozen", trial_commas, 0);
    resync_en = 1'b1;
    trial($urandom_range(1, 19), "R4");
    do_reset();
    trial(5, "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule